// File: doc/BRIEF.md
# Interrupt Status Unit for a Memory Interface

This unit collects the interrupt sources of an external memory interface and drives a single interrupt line. Three kinds of event arrive at its inputs. One group is the wait-pin rising-edge detectors, one per wait input, which are parameterised in number. The second is a one-cycle pulse that flags an illegal access, called a line trap. The third is a one-cycle pulse that flags an asynchronous timeout. The timeout fires when an extended access holds its wait signal active for longer than the programmed maximum wait count. That counting happens outside this unit.

For every source the unit keeps three bits: a raw status bit, a masked status bit and an enable bit. Software reaches them through four views chosen by a 2-bit selector. A write to a status view clears bits by writing ones. A write to an enable view sets or clears enable bits by writing ones. The interrupt output is asserted while any masked status bit is set. The wait inputs are asynchronous and are synchronised inside the unit before edge detection.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, and after any later reset, all four views read 0 and `irq_o` is low.
- R2: The bit layout is identical in every view: bit 0 is async timeout, bit 1 is line trap, and bit 2+n is the rising edge of wait input n. Bits above NUM_WAIT+1 always read 0. The view codes are 0 raw, 1 masked, 2 enable-set and 3 enable-clear.
- R3: An event sets its raw bit. Writing 1 to that bit in the raw view clears it. Writing 0 leaves it unchanged.
- R4: A wait bit is set only by a low-to-high transition of its synchronised input. A level held high does not set the bit again after it has been cleared, and a falling edge does not set it. No polarity setting takes part in this detection.
- R5: Writing 1 to a bit in either the raw view or the masked view clears that bit in both the raw and the masked status.
- R6: A masked bit is set only by an event that occurs while its enable bit is 1. Clearing the enable bit afterwards does not clear a masked bit that is already set.
- R7: Writing 1 in the enable-set view sets enable bits, and writing 1 in the enable-clear view clears them. Writing 0 to either view changes nothing. Both views always return the same enable value.
- R8: `irq_o` is high exactly when at least one masked status bit is 1.
- R9: When an event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R10: Write data bits above NUM_WAIT+1 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_pin_i | input | NUM_WAIT | Asynchronous wait inputs whose rising edges are recorded |
| line_trap_i | input | 1 | One-cycle pulse flagging an illegal access |
| async_tmo_i | input | 1 | One-cycle pulse flagging an extended-wait timeout |
| wr_en_i | input | 1 | Write strobe for the selected view |
| view_sel_i | input | 2 | View select: 0 raw, 1 masked, 2 enable-set, 3 enable-clear |
| wr_data_i | input | DATA_W | Write data; only bits NUM_WAIT+1..0 are used |
| rd_data_o | output | DATA_W | Contents of the selected view, zero-extended |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that `line_trap_i` and `async_tmo_i` are clean, clock-synchronous pulses. They also assume that a wait input holds each level for at least two clock cycles, so that the synchroniser produces a single rise indication per edge. The stimulus raises the event pulses for exactly one cycle between falling clock edges. It holds wait inputs high for two cycles or longer before dropping them, and it lets the synchroniser settle before it reads any view.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;

    typedef enum logic [1:0] {
        VIEW_RAW    = 2'd0,
        VIEW_MASKED = 2'd1,
        VIEW_EN_SET = 2'd2,
        VIEW_EN_CLR = 2'd3
    } view_e;

    localparam int TMO_BIT  = 0;
    localparam int TRAP_BIT = 1;
    localparam int WAIT_LSB = 2;

endpackage

// File: rtl/wait_rise_det.sv
`timescale 1ns/1ps
module wait_rise_det #(
    parameter int NUM_WAIT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAIT-1:0] pin_i,
    output logic [NUM_WAIT-1:0] rise_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_WAIT-1:0] stg;
        logic [NUM_WAIT-1:0]                  prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d        = det_q;
        det_d.stg[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            det_d.stg[i] = det_q.stg[i-1];
        end
        det_d.prev   = det_q.stg[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign rise_o = det_q.stg[LAST] & ~det_q.prev;

endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg #(
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] en_o
);

    typedef struct packed {
        logic [NB-1:0] en;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d    = en_q;
        en_d.en = (en_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q.en;

endmodule

// File: rtl/irq_status_core.sv
`timescale 1ns/1ps
module irq_status_core #(
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] evt_i,
    input  logic [NB-1:0] en_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] raw_o,
    output logic [NB-1:0] masked_o
);

    typedef struct packed {
        logic [NB-1:0] raw;
        logic [NB-1:0] masked;
    } stat_t;

    stat_t st_d, st_q;

    // A clear and an event in the same cycle: the event is applied last and wins.
    always_comb begin
        st_d        = st_q;
        st_d.raw    = (st_q.raw    & ~clr_i) | evt_i;
        st_d.masked = (st_q.masked & ~clr_i) | (evt_i & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o    = st_q.raw;
    assign masked_o = st_q.masked;

endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int NUM_WAIT    = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAIT-1:0] wait_pin_i,
    input  logic                line_trap_i,
    input  logic                async_tmo_i,
    input  logic                wr_en_i,
    input  logic [1:0]          view_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_o
);

    localparam int NB = NUM_WAIT + WAIT_LSB;

    view_e         view;
    logic [NB-1:0] wr_bits;
    logic [NB-1:0] evt_vec;
    logic [NUM_WAIT-1:0] wait_rise;
    logic [NB-1:0] stat_clr, en_set, en_clr;
    logic [NB-1:0] raw_q, masked_q, en_q;
    logic          unused_wr_hi;

    assign view         = view_e'(view_sel_i);
    assign wr_bits      = wr_data_i[NB-1:0];
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:NB];

    wait_rise_det #(
        .NUM_WAIT    (NUM_WAIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (wait_pin_i),
        .rise_o (wait_rise)
    );

    always_comb begin
        evt_vec                         = '0;
        evt_vec[TMO_BIT]                = async_tmo_i;
        evt_vec[TRAP_BIT]               = line_trap_i;
        evt_vec[NB-1:WAIT_LSB]          = wait_rise;
    end

    always_comb begin
        stat_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        if (wr_en_i) begin
            unique case (view)
                VIEW_RAW, VIEW_MASKED: stat_clr = wr_bits;
                VIEW_EN_SET:           en_set   = wr_bits;
                VIEW_EN_CLR:           en_clr   = wr_bits;
                default:               stat_clr = '0;
            endcase
        end
    end

    irq_enable_reg #(.NB(NB)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_q)
    );

    irq_status_core #(.NB(NB)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_vec),
        .en_i     (en_q),
        .clr_i    (stat_clr),
        .raw_o    (raw_q),
        .masked_o (masked_q)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (view)
            VIEW_RAW:                 rd_data_o[NB-1:0] = raw_q;
            VIEW_MASKED:              rd_data_o[NB-1:0] = masked_q;
            VIEW_EN_SET, VIEW_EN_CLR: rd_data_o[NB-1:0] = en_q;
            default:                  rd_data_o         = '0;
        endcase
    end

    assign irq_o = |masked_q;

endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk #(
    parameter int NUM_WAIT = 4,
    parameter int NB       = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          view_sel,
    input logic [NB-1:0]       wr_bits,
    input logic                line_trap,
    input logic                async_tmo,
    input logic [NUM_WAIT-1:0] wait_rise,
    input logic [NB-1:0]       raw,
    input logic [NB-1:0]       masked,
    input logic [NB-1:0]       en,
    input logic                irq
);

    // R5: a clear always hits both views, so masked never exceeds raw
    assert_masked_within_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked & ~raw) == '0);

    // R8: the interrupt only rises after some event input was active
    assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(line_trap || async_tmo || (|wait_rise)));

    // R3: write-one to a status view clears the timeout bit when no event competes
    assert_w1_clears_tmo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !view_sel[1] && wr_bits[0] && !async_tmo) |=> !raw[0]);

    // R3: without a write no raw bit ever drops
    assert_raw_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(raw) & ~raw) == '0));

    // R7: enable bits change only through the two enable views
    assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && view_sel[1]) |=> $stable(en));

    // R6: with the enable off, a clear masked trap bit stays clear
    assert_masked_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[1] && !masked[1]) |=> !masked[1]);

endmodule

bind irq_status_unit irq_status_chk #(
    .NUM_WAIT (NUM_WAIT),
    .NB       (NUM_WAIT + 2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .view_sel  (view_sel_i),
    .wr_bits   (wr_data_i[NUM_WAIT+1:0]),
    .line_trap (line_trap_i),
    .async_tmo (async_tmo_i),
    .wait_rise (wait_rise),
    .raw       (raw_q),
    .masked    (masked_q),
    .en        (en_q),
    .irq       (irq_o)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;

    localparam int NUM_WAIT = 4;
    localparam int DATA_W   = 32;
    localparam int NSTEP    = 16;

    localparam logic [1:0] K_WR = 2'd0, K_EV = 2'd1;
    localparam logic [1:0] V_RAW = 2'd0, V_MSK = 2'd1, V_SET = 2'd2, V_CLR = 2'd3;

    // {kind, view, data, exp_raw, exp_masked, exp_en, exp_irq}
    localparam logic [28:0] TBL [0:NSTEP-1] = '{
        {K_WR, V_SET, 6'h03, 6'h00, 6'h00, 6'h03, 1'b0}, // R7 enable trap+tmo
        {K_EV, V_RAW, 6'h03, 6'h03, 6'h03, 6'h03, 1'b1}, // R3 R6 R8 pulses
        {K_EV, V_RAW, 6'h14, 6'h17, 6'h03, 6'h03, 1'b1}, // R4 R2 wait 0 and 2 rise
        {K_WR, V_RAW, 6'h00, 6'h17, 6'h03, 6'h03, 1'b1}, // R3 write zero
        {K_WR, V_RAW, 6'h01, 6'h16, 6'h02, 6'h03, 1'b1}, // R5 raw view clears both
        {K_WR, V_MSK, 6'h02, 6'h14, 6'h00, 6'h03, 1'b0}, // R5 R8 masked view clears both
        {K_WR, V_CLR, 6'h00, 6'h14, 6'h00, 6'h03, 1'b0}, // R7 write zero to clear view
        {K_WR, V_SET, 6'h3C, 6'h14, 6'h00, 6'h3F, 1'b0}, // R7 enable waits
        {K_EV, V_RAW, 6'h3C, 6'h3C, 6'h3C, 6'h3F, 1'b1}, // R4 R6 all waits
        {K_WR, V_CLR, 6'h3F, 6'h3C, 6'h3C, 6'h00, 1'b1}, // R6 R7 disable keeps masked
        {K_EV, V_RAW, 6'h01, 6'h3D, 6'h3C, 6'h00, 1'b1}, // R6 event while disabled
        {K_WR, V_MSK, 6'h00, 6'h3D, 6'h3C, 6'h00, 1'b1}, // R5 write zero masked
        {K_WR, V_RAW, 6'h3F, 6'h00, 6'h00, 6'h00, 1'b0}, // R3 R8 clear all
        {K_WR, V_SET, 6'h02, 6'h00, 6'h00, 6'h02, 1'b0}, // R7
        {K_EV, V_RAW, 6'h02, 6'h02, 6'h02, 6'h02, 1'b1}, // R3 R6 trap only
        {K_WR, V_MSK, 6'h02, 6'h00, 6'h00, 6'h02, 1'b0}  // R5 R8
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_WAIT-1:0] wait_pin = '0;
    logic                line_trap = 1'b0;
    logic                async_tmo = 1'b0;
    logic                wr_en = 1'b0;
    logic [1:0]          view_sel = 2'd0;
    logic [DATA_W-1:0]   wr_data = '0;
    logic [DATA_W-1:0]   rd_data;
    logic                irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    irq_status_unit #(.NUM_WAIT(NUM_WAIT), .DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_pin_i  (wait_pin),
        .line_trap_i (line_trap),
        .async_tmo_i (async_tmo),
        .wr_en_i     (wr_en),
        .view_sel_i  (view_sel),
        .wr_data_i   (wr_data),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] v, output logic [31:0] d);
        view_sel = v;
        #0.1;
        d = rd_data;
    endtask

    task automatic chk_views(input string tag, input logic [5:0] raw, input logic [5:0] msk,
                             input logic [5:0] en, input logic ex_irq);
        logic [31:0] d;
        @(negedge clk);
        rd(V_RAW, d); chk({tag, " raw"}, d, {26'd0, raw});
        rd(V_MSK, d); chk({tag, " masked"}, d, {26'd0, msk});
        rd(V_SET, d); chk({tag, " en-set view"}, d, {26'd0, en});
        rd(V_CLR, d); chk({tag, " en-clr view"}, d, {26'd0, en});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, ex_irq});
    endtask

    task automatic do_write(input logic [1:0] v, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; view_sel = v; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_event(input logic [5:0] d);
        @(negedge clk);
        wait_pin = d[5:2]; line_trap = d[1]; async_tmo = d[0];
        @(negedge clk);
        line_trap = 1'b0; async_tmo = 1'b0;
        @(negedge clk);
        wait_pin = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();
        chk_views("R1 initial reset", 6'h00, 6'h00, 6'h00, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            logic [28:0] s;
            s = TBL[i];
            if (s[28:27] == K_WR) do_write(s[26:25], {26'd0, s[24:19]});
            else                  do_event(s[24:19]);
            chk_views($sformatf("table step %0d", i), s[18:13], s[12:7], s[6:1], s[0]);
        end

        // R1: reset in the middle of activity
        do_write(V_SET, 32'h3F);
        do_event(6'h3F);
        do_reset();
        chk_views("R1 mid-run reset", 6'h00, 6'h00, 6'h00, 1'b0);

        // R10 R2: upper write bits ignored and read as 0
        do_event(6'h01);
        do_write(V_RAW, 32'hFFFF_FFC0);
        do_write(V_SET, 32'hFFFF_FFC0);
        chk_views("R10 upper bits ignored", 6'h01, 6'h00, 6'h00, 1'b0);
        @(negedge clk);
        rd(V_RAW, d); chk("R2 full raw word", d, 32'h0000_0001);
        do_write(V_RAW, 32'h01);

        // R4: held level and falling edge do not set the bit again
        @(negedge clk);
        wait_pin = 4'b0001;
        repeat (6) @(negedge clk);
        rd(V_RAW, d); chk("R4 rise sets wait bit", d, 32'h04);
        do_write(V_RAW, 32'h04);
        repeat (5) @(negedge clk);
        rd(V_RAW, d); chk("R4 held level no retrigger", d, 32'h00);
        wait_pin = '0;
        repeat (6) @(negedge clk);
        rd(V_RAW, d); chk("R4 falling edge ignored", d, 32'h00);

        // R9: event and clear in the same cycle, set wins
        do_write(V_SET, 32'h02);
        @(negedge clk);
        line_trap = 1'b1; wr_en = 1'b1; view_sel = V_RAW; wr_data = 32'h02;
        @(negedge clk);
        line_trap = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk_views("R9 set beats clear", 6'h02, 6'h02, 6'h02, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule